// File: doc/BRIEF.md
# Even/Odd Rectified Voltage Averager

In bridge converters two PWM outputs drive alternating half-cycles, here named even and odd. For every half-cycle a tracked rectified-voltage sample arrives together with a valid strobe and a phase tag. The tag says which PWM produced the sample. The block keeps the most recent even sample and the most recent odd sample in separate registers. A volt-second balancing function reads those two registers directly.

The block also keeps a running mean of the two stored values for telemetry and feed-forward. The mean is refreshed after every half-cycle. The newest sample is paired with the latest sample of the other phase, so a fresh even sample n+1 gives (even[n+1] + odd[n]) / 2. Each register update comes with its own one-clock strobe. The mean is flagged valid only after both phases have been seen since reset.

Top module: `vrect_pair_avg`

## Requirements
- R1: While reset is asserted and in the first cycle after it, evenOut, oddOut and avgOut are zero, and avgValid, evenStrobe, oddStrobe and avgStrobe are low.
- R2: A sample with sampleValid high and samplePhase = 0 (even) appears on evenOut one cycle later. The same sample leaves oddOut unchanged.
- R3: A sample with sampleValid high and samplePhase = 1 (odd) appears on oddOut one cycle later. The same sample leaves evenOut unchanged.
- R4: evenStrobe, or oddStrobe for the odd phase, is high for exactly the one cycle in which the register for that sample's phase first shows the new value.
- R5: avgOut equals (evenOut + oddOut) >> 1. The sum is formed one bit wider than the sample, so all-ones inputs give an all-ones average with no overflow, and an odd sum is truncated.
- R6: Once both phases have been seen, every accepted sample recomputes avgOut two cycles after the sample. The new value pairs the new sample with the stored value of the other phase, and avgStrobe is high in that same cycle.
- R7: Until at least one even and one odd sample have been accepted since reset, avgOut stays zero and avgValid and avgStrobe stay low. avgValid rises with the first avgStrobe and then stays high.
- R8: Two or more samples of the same phase in a row each overwrite that phase's register, and each one triggers its own recomputation of the average.
- R9: While sampleValid is low, sampleIn and samplePhase have no effect on any output. Every output keeps its value apart from strobes that are still finishing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleIn | input | SAMPLE_W | Tracked rectified-voltage sample |
| sampleValid | input | 1 | Sample strobe |
| samplePhase | input | 1 | 0 = even PWM, 1 = odd PWM |
| evenOut | output | SAMPLE_W | Latest even sample |
| oddOut | output | SAMPLE_W | Latest odd sample |
| avgOut | output | SAMPLE_W | Mean of latest even and odd samples |
| avgValid | output | 1 | Both phases have been seen |
| evenStrobe | output | 1 | evenOut just updated |
| oddStrobe | output | 1 | oddOut just updated |
| avgStrobe | output | 1 | avgOut just updated |

## Verification
The phase registers and their strobes change in the cycle after a sample is accepted. avgOut, avgStrobe and avgValid follow one cycle after that, two cycles after the sample. The bench drives its inputs on the falling edge and carries a behavioural model through the same two stages. At every falling edge it compares all outputs against the model. The stimulus covers samples of one phase only, alternating phases, repeated phases, idle gaps with garbage on the data lines, and all-ones values.

// File: rtl/vrect_pkg.sv
package vrect_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadEven;
    logic loadOdd;
    logic loadAvg;
  } vrect_ctrl_t;
endpackage

// File: rtl/vrect_ctrl.sv
module vrect_ctrl
  import vrect_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        samplePhase,
  output vrect_ctrl_t ctrl,
  output logic        evenStrobe,
  output logic        oddStrobe,
  output logic        avgStrobe,
  output logic        avgValid
);
  logic seenEvenQ, seenOddQ, updPendQ;

  always_comb begin
    ctrl.loadEven = sampleValid && !samplePhase;
    ctrl.loadOdd  = sampleValid &&  samplePhase;
    ctrl.loadAvg  = updPendQ && seenEvenQ && seenOddQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seenEvenQ  <= 1'b0;
      seenOddQ   <= 1'b0;
      updPendQ   <= 1'b0;
      evenStrobe <= 1'b0;
      oddStrobe  <= 1'b0;
      avgStrobe  <= 1'b0;
      avgValid   <= 1'b0;
    end else begin
      if (ctrl.loadEven) seenEvenQ <= 1'b1;
      if (ctrl.loadOdd)  seenOddQ  <= 1'b1;
      updPendQ   <= sampleValid;
      evenStrobe <= ctrl.loadEven;
      oddStrobe  <= ctrl.loadOdd;
      avgStrobe  <= ctrl.loadAvg;
      if (ctrl.loadAvg) avgValid <= 1'b1;
    end
  end

  // R4: one sample updates only one phase
  a_r4_one_phase: assert property (@(posedge clk) disable iff (!rstN)
    !(evenStrobe && oddStrobe));
  // R7: an average update implies it is valid
  a_r7_strobe_valid: assert property (@(posedge clk) disable iff (!rstN)
    avgStrobe |-> avgValid);
  // R7: valid never drops once set
  a_r7_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    avgValid |=> avgValid);
  // R6: a sample that completes the pair set yields an average two cycles on
  a_r6_avg_due: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && (seenEvenQ || !samplePhase) && (seenOddQ || samplePhase))
      |=> ##1 avgStrobe);
endmodule

// File: rtl/vrect_datapath.sv
module vrect_datapath
  import vrect_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  vrect_ctrl_t         ctrl,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] evenReg,
  output logic [SAMPLE_W-1:0] oddReg,
  output logic [SAMPLE_W-1:0] avgReg
);
  localparam int SUM_W = SAMPLE_W + 1;

  logic [SUM_W-1:0] pairSum;

  always_comb pairSum = {1'b0, evenReg} + {1'b0, oddReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evenReg <= '0;
      oddReg  <= '0;
      avgReg  <= '0;
    end else begin
      if (ctrl.loadEven) evenReg <= sampleIn;
      if (ctrl.loadOdd)  oddReg  <= sampleIn;
      if (ctrl.loadAvg)  avgReg  <= pairSum[SUM_W-1:1];
    end
  end

  // R2: even capture
  a_r2_even_load: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadEven |=> evenReg == $past(sampleIn));
  // R3: odd capture
  a_r3_odd_load: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadOdd |=> oddReg == $past(sampleIn));
  // R9: no load keeps both registers
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.loadEven || ctrl.loadOdd) |=> ($stable(evenReg) && $stable(oddReg)));
  // R5: the mean lies between the two inputs
  a_r5_bounded: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadAvg |=>
      ((avgReg >= $past(evenReg) || avgReg >= $past(oddReg)) &&
       (avgReg <= $past(evenReg) || avgReg <= $past(oddReg))));
endmodule

// File: rtl/vrect_pair_avg.sv
module vrect_pair_avg
  import vrect_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                sampleValid,
  input  logic                samplePhase,
  output logic [SAMPLE_W-1:0] evenOut,
  output logic [SAMPLE_W-1:0] oddOut,
  output logic [SAMPLE_W-1:0] avgOut,
  output logic                avgValid,
  output logic                evenStrobe,
  output logic                oddStrobe,
  output logic                avgStrobe
);
  vrect_ctrl_t ctrl;

  vrect_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .samplePhase(samplePhase),
    .ctrl(ctrl), .evenStrobe(evenStrobe), .oddStrobe(oddStrobe),
    .avgStrobe(avgStrobe), .avgValid(avgValid)
  );

  vrect_datapath #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sampleIn(sampleIn),
    .evenReg(evenOut), .oddReg(oddOut), .avgReg(avgOut)
  );
endmodule

// File: tb/vrect_pair_avg_bench.sv
`timescale 1ns/1ps
module vrect_pair_avg_bench;
  localparam int W = 12;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] sampleIn = '0;
  logic sampleValid = 1'b0;
  logic samplePhase = 1'b0;
  logic [W-1:0] evenOut, oddOut, avgOut;
  logic avgValid, evenStrobe, oddStrobe, avgStrobe;

  always #2 clk = ~clk;

  vrect_pair_avg #(.SAMPLE_W(W)) u_vrect_pair_avg (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .samplePhase(samplePhase), .evenOut(evenOut), .oddOut(oddOut),
    .avgOut(avgOut), .avgValid(avgValid), .evenStrobe(evenStrobe),
    .oddStrobe(oddStrobe), .avgStrobe(avgStrobe)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model state
  int mEven = 0, mOdd = 0, mAvg = 0;
  bit mSeenE = 0, mSeenO = 0, mValid = 0, mStrE = 0, mStrO = 0, mStrA = 0, mPend = 0;
  int pendQ[$];

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // advance the model by the edge that just passed, using the inputs held there
  task automatic modelStep(bit v, bit ph, int d);
    mStrA = 0;
    if (mPend && mSeenE && mSeenO) begin   // R6: pairs registers before this edge
      mAvg = (mEven + mOdd) / 2;
      mStrA = 1;
      mValid = 1;
    end
    mPend = v;
    mStrE = v && !ph;
    mStrO = v && ph;
    if (mStrE) begin mEven = d; mSeenE = 1; end
    if (mStrO) begin mOdd = d; mSeenO = 1; end
    pendQ.push_back(d);
    if (pendQ.size() > 4) void'(pendQ.pop_front());
  endtask

  task automatic compareAll(string ctx);
    check({"R2 evenOut ", ctx}, evenOut, mEven);
    check({"R3 oddOut ", ctx}, oddOut, mOdd);
    check({"R5 R6 avgOut ", ctx}, avgOut, mAvg);
    check({"R7 avgValid ", ctx}, avgValid, mValid);
    check({"R4 evenStrobe ", ctx}, evenStrobe, mStrE);
    check({"R4 oddStrobe ", ctx}, oddStrobe, mStrO);
    check({"R6 avgStrobe ", ctx}, avgStrobe, mStrA);
  endtask

  // one cycle: inputs set at a falling edge are sampled at the next rising edge
  task automatic cyc(bit v, bit ph, int d, string ctx);
    sampleValid = v; samplePhase = ph; sampleIn = d[W-1:0];
    @(negedge clk);
    modelStep(v, ph, d);
    compareAll(ctx);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    compareAll("R1 in reset");
    rstN = 1'b1;
    cyc(0, 0, 0, "R1 after reset");

    // R7: even only, average stays invalid
    cyc(1, 0, 100, "R7 first even");
    cyc(1, 0, 300, "R8 even repeat");
    cyc(0, 1, 999, "R9 idle garbage");
    cyc(0, 0, 777, "R7 still invalid");
    check("R7 avgOut zero before pair", avgOut, 0);
    // first odd completes the pair
    cyc(1, 1, 201, "R3 first odd");
    cyc(0, 0, 0, "R6 first avg");
    check("R6 R5 first average truncated", avgOut, (300 + 201) / 2);
    cyc(0, 0, 0, "R6 settle");

    // alternating back to back
    for (int i = 0; i < 20; i++) cyc(1, i[0], 50 * i + 7, "R6 alternate");
    // repeated odd
    for (int i = 0; i < 4; i++) cyc(1, 1, 1000 + i, "R8 odd run");
    cyc(0, 0, 0, "R8 drain");
    cyc(0, 0, 0, "R8 drain2");
    check("R8 last odd kept", oddOut, 1003);

    // R5: all-ones no overflow
    cyc(1, 0, MAXV, "R5 max even");
    cyc(1, 1, MAXV, "R5 max odd");
    cyc(0, 0, 0, "R5 wait");
    cyc(0, 0, 0, "R5 wait2");
    check("R5 all ones average", avgOut, MAXV);

    // idle with garbage
    for (int i = 0; i < 6; i++) cyc(0, i[0], 123 * i, "R9 idle");

    // random traffic
    for (int i = 0; i < 300; i++) begin
      int r = $urandom;
      cyc(r[0] | r[1], r[2], (r >> 8) & MAXV, "R6 random");
    end
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, "tail");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule